// File: doc/BRIEF.md
# Horizontal Block Derivative Filter

This stage takes an image as a stream of pixel blocks. Each block carries a fixed number of unsigned 8-bit pixels. Rows arrive left to right, and rows are taken top to bottom. For every pixel the stage computes a 5-tap horizontal derivative and emits a block of signed 16-bit results. To filter the pixels at a block's edges it needs two pixels from each neighbouring block in the same row. It therefore holds one block back, and each output block is emitted one input block late.

Pixels outside a row are treated as zero, so every row is filtered on its own. The image size is given as two configuration inputs: rows per image and blocks per row. These are captured when the first block of an image is accepted. After the final block of an image, the stage runs one extra step that consumes no input and emits the last output block. Both sides use a valid/ready handshake, and the output is registered.

Top module: `hderiv_stage`

## Requirements
- R1: For a lane at pixel column c, the result is p[c-2] + 2·p[c-1] − 2·p[c+1] − p[c+2]. Pixels are read as unsigned and the result is signed 16-bit. Pixel k of a block is at in_data_i[8k+7:8k], and result k is at out_data_o[16k+15:16k].
- R2: The n-th output block of an image belongs to the n-th input block. Its right-hand neighbours are the first two pixels of the next block in the same row, and its left-hand neighbours are the last two pixels of the previous block in the same row.
- R3: Pixels left of a row's first block read as zero, and so do pixels right of a row's last block. No pixel from another row or another image enters a result.
- R4: Accepting the first block of an image produces no output. An image of R rows and B blocks per row yields exactly R·B output blocks and no more.
- R5: Once the last block of an image is accepted, in_ready_o stays low until the final output block has been loaded into the output register. The stage then accepts a new image.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value. No accepted input is lost or repeated.
- R7: in_ready_o is low while start_i is low. rows_i and bpr_i are sampled when the first block of an image is accepted, and changes to them later in that image have no effect.
- R8: While rst_ni is low, out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enables intake of input blocks |
| rows_i | input | CFG_W | Rows per image |
| bpr_i | input | CFG_W | Blocks per row |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Input block accepted when high together with valid |
| in_data_i | input | 8·LANES | Pixel block |
| out_valid_o | output | 1 | Result block valid |
| out_ready_i | input | 1 | Downstream accepts the result block |
| out_data_o | output | 16·LANES | Result block |

## Verification
Two events can fall in the same cycle. One is the flush step that emits an image's final block. The other is the downstream consumer draining, or refusing, the previous result. The bench provokes this with one-row and one-block images and with random back-pressure, so the flush must wait on a held output register. Each result is judged lane by lane against a zero-padded reference filter. The bench also checks that input stays blocked during the flush, that held results remain stable, and that the block count comes out exact with no stray output afterwards.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int PIX_W = 8;
  localparam int RES_W = 16;
  localparam int HALO  = 2;

  typedef logic signed [RES_W-1:0] res_t;

  // taps 1,2,0,-2,-1 on unsigned pixels widened to signed
  function automatic res_t deriv5(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
                                  input logic [PIX_W-1:0] d, input logic [PIX_W-1:0] e);
    res_t pa, pb, pd, pe;
    pa = res_t'(a);
    pb = res_t'(b);
    pd = res_t'(d);
    pe = res_t'(e);
    return pa + (pb <<< 1) - (pd <<< 1) - pe;
  endfunction
endpackage

// File: rtl/hd_tracker.sv
module hd_tracker #(
  parameter int CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] rows_i,
  input  logic [CFG_W-1:0] bpr_i,
  input  logic             in_step_i,
  input  logic             flush_step_i,
  output logic             origin_o,
  output logic             row_first_o,
  output logic             flush_o,
  output logic [CFG_W-1:0] jc_o,
  output logic [CFG_W-1:0] ip_o
);
  logic [CFG_W-1:0] rows_q, bpr_q, jc_q, ip_q;
  logic             flush_q;
  logic [CFG_W-1:0] rows_eff, bpr_eff;
  logic [CFG_W:0]   jc_inc, ip_inc;

  assign origin_o    = (jc_q == '0) && (ip_q == '0) && !flush_q;
  assign row_first_o = (jc_q == '0);
  assign flush_o     = flush_q;
  assign jc_o        = jc_q;
  assign ip_o        = ip_q;
  assign rows_eff    = origin_o ? rows_i : rows_q;
  assign bpr_eff     = origin_o ? bpr_i  : bpr_q;
  assign jc_inc      = {1'b0, jc_q} + 1'b1;
  assign ip_inc      = {1'b0, ip_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_q  <= '0;
      bpr_q   <= '0;
      jc_q    <= '0;
      ip_q    <= '0;
      flush_q <= 1'b0;
    end else if (in_step_i) begin
      if (origin_o) begin
        rows_q <= rows_i;
        bpr_q  <= bpr_i;
      end
      if (jc_inc >= {1'b0, bpr_eff}) begin
        jc_q <= '0;
        ip_q <= ip_inc[CFG_W-1:0];
        if (ip_inc == {1'b0, rows_eff}) flush_q <= 1'b1;
      end else begin
        jc_q <= jc_inc[CFG_W-1:0];
      end
    end else if (flush_step_i) begin
      jc_q    <= '0;
      ip_q    <= '0;
      flush_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hd_window.sv
module hd_window
  import hd_pkg::*;
#(
  parameter int LANES = 8,
  localparam int BLK_W = LANES * PIX_W,
  localparam int HAL_W = HALO * PIX_W,
  localparam int WIN_W = BLK_W + 2 * HAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             row_first_i,
  input  logic             flush_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [WIN_W-1:0] win_o
);
  logic [HAL_W-1:0] left_q, right_w;
  logic [BLK_W-1:0] last_q;

  // right halo comes from the incoming block only inside a row
  assign right_w = (flush_i || row_first_i) ? '0 : blk_i[HAL_W-1:0];
  assign win_o   = {right_w, last_q, left_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      last_q <= '0;
    end else if (load_i) begin
      left_q <= row_first_i ? '0 : last_q[BLK_W-1 -: HAL_W];
      last_q <= blk_i;
    end
  end
endmodule

// File: rtl/hd_lanes.sv
module hd_lanes
  import hd_pkg::*;
#(
  parameter int LANES = 8,
  localparam int WIN_W = (LANES + 2 * HALO) * PIX_W,
  localparam int OUT_W = LANES * RES_W
) (
  input  logic [WIN_W-1:0] win_i,
  output logic [OUT_W-1:0] res_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign res_o[RES_W*g +: RES_W] = deriv5(win_i[PIX_W*g       +: PIX_W],
                                            win_i[PIX_W*(g + 1) +: PIX_W],
                                            win_i[PIX_W*(g + 3) +: PIX_W],
                                            win_i[PIX_W*(g + 4) +: PIX_W]);
  end
endmodule

// File: rtl/hderiv_stage.sv
module hderiv_stage
  import hd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CFG_W = 16,
  localparam int BLK_W = LANES * PIX_W,
  localparam int OUT_W = LANES * RES_W,
  localparam int WIN_W = BLK_W + 2 * HALO * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] rows_i,
  input  logic [CFG_W-1:0] bpr_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [BLK_W-1:0] in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o
);
  logic             origin_w, row_first_w, flush_w;
  logic [CFG_W-1:0] jc_w, ip_w;
  logic             out_space, in_fire, flush_fire, emit;
  logic [WIN_W-1:0] win_w;
  logic [OUT_W-1:0] res_w;
  logic             vld_q;
  logic [OUT_W-1:0] out_q;

  assign out_space  = !vld_q || out_ready_i;
  assign in_ready_o = start_i && !flush_w && out_space;
  assign in_fire    = in_valid_i && in_ready_o;
  assign flush_fire = flush_w && out_space;
  assign emit       = flush_fire || (in_fire && !origin_w);

  hd_tracker #(.CFG_W(CFG_W)) u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rows_i       (rows_i),
    .bpr_i        (bpr_i),
    .in_step_i    (in_fire),
    .flush_step_i (flush_fire),
    .origin_o     (origin_w),
    .row_first_o  (row_first_w),
    .flush_o      (flush_w),
    .jc_o         (jc_w),
    .ip_o         (ip_w)
  );

  hd_window #(.LANES(LANES)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (in_fire),
    .row_first_i (row_first_w),
    .flush_i     (flush_w),
    .blk_i       (in_data_i),
    .win_o       (win_w)
  );

  hd_lanes #(.LANES(LANES)) u_lanes (
    .win_i (win_w),
    .res_o (res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else if (emit) begin
      vld_q <= 1'b1;
      out_q <= res_w;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = out_q;
endmodule

// File: rtl/hderiv_stage_chk.sv
module hderiv_stage_chk #(
  parameter int OUT_W = 128,
  parameter int CFG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             flush_w,
  input logic             origin_w,
  input logic [CFG_W-1:0] jc_w,
  input logic [CFG_W-1:0] ip_w
);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_flush_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |-> !in_ready_o);

  assert_flush_rewind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w && (!out_valid_o || out_ready_i) |=> !flush_w && jc_w == '0 && ip_w == '0);

  assert_first_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    origin_w && in_valid_i && in_ready_o |=> !out_valid_o);

  assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> !in_ready_o);

  always_comb begin
    if (!rst_ni) assert_reset_R8: assert (!out_valid_o);
  end
endmodule

bind hderiv_stage hderiv_stage_chk #(.OUT_W(OUT_W), .CFG_W(CFG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .flush_w     (flush_w),
  .origin_w    (origin_w),
  .jc_w        (jc_w),
  .ip_w        (ip_w)
);

// File: tb/hderiv_stage_test.sv
`timescale 1ns/1ps
module hderiv_stage_test;
  localparam int LANES = 8;
  localparam int CFG_W = 16;
  localparam int MAXR  = 5;
  localparam int MAXB  = 4;
  localparam int NCASE = 6;
  // rows, blocks per row, input gaps, output stalls, config scramble
  localparam int CASES [NCASE][5] = '{
    '{1, 1, 0, 0, 0},
    '{1, 3, 0, 0, 0},
    '{3, 2, 1, 0, 0},
    '{2, 4, 0, 1, 0},
    '{4, 3, 1, 1, 1},
    '{5, 1, 1, 1, 0}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   start_i = 1'b0;
  logic [CFG_W-1:0]       rows_i = '0;
  logic [CFG_W-1:0]       bpr_i = '0;
  logic                   in_valid_i = 1'b0;
  logic                   in_ready_o;
  logic [LANES*8-1:0]     in_data_i = '0;
  logic                   out_valid_o;
  logic                   out_ready_i = 1'b1;
  logic [LANES*16-1:0]    out_data_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  logic [7:0] img [MAXR*MAXB*LANES];

  always #2.5 clk_i = ~clk_i;

  hderiv_stage #(.LANES(LANES), .CFG_W(CFG_W)) uut (.*);

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int px(int r, int c, int bpr);
    if (c < 0 || c >= bpr * LANES) return 0;
    return int'(img[r * bpr * LANES + c]);
  endfunction

  function automatic logic [LANES*16-1:0] ref_blk(int idx, int bpr);
    logic [LANES*16-1:0] v;
    int r, c, s;
    r = idx / bpr;
    for (int l = 0; l < LANES; l++) begin
      c = (idx % bpr) * LANES + l;
      s = px(r, c-2, bpr) + 2*px(r, c-1, bpr) - 2*px(r, c+1, bpr) - px(r, c+2, bpr);
      v[16*l +: 16] = s[15:0];
    end
    return v;
  endfunction

  task automatic run_image(input int rows, input int bpr, input int gap, input int stall, input int scr);
    int total, ii, oi;
    logic hold;
    logic [LANES*16-1:0] held;
    logic flush_seen;
    total = rows * bpr;
    ii = 0; oi = 0; hold = 1'b0; held = '0; flush_seen = 1'b0;
    for (int k = 0; k < total * LANES; k++) img[k] = 8'($urandom);
    for (int k = 0; k < 4 && total > 1; k++) img[k] = 8'hFF;  // extreme values on first pixels
    rows_i = CFG_W'(rows); bpr_i = CFG_W'(bpr); start_i = 1'b1;
    while (oi < total) begin
      @(negedge clk_i);
      out_ready_i = stall != 0 ? ($urandom % 3 != 0) : 1'b1;
      if (scr != 0 && ii > 0) begin rows_i = 16'd7; bpr_i = 16'd3; end
      if (ii < total) begin
        in_valid_i = gap != 0 ? ($urandom % 2 == 0) : 1'b1;
        for (int l = 0; l < LANES; l++) in_data_i[8*l +: 8] = img[ii * LANES + l];
      end else begin
        in_valid_i = 1'b0;
      end
      #1;
      if (hold) begin  // R6 result held under back-pressure
        check("R6", {127'b0, out_valid_o}, 128'd1);
        check("R6", out_data_o, held);
      end
      hold = out_valid_o && !out_ready_i;
      held = out_data_o;
      if (ii == total && !flush_seen) begin  // R5 intake closed after last block
        flush_seen = 1'b1;
        check("R5", {127'b0, in_ready_o}, 128'd0);
      end
      if (out_valid_o && out_ready_i) begin  // R1 R2 R3 lane values
        check("R1/R2/R3", out_data_o, ref_blk(oi, bpr));
        oi++;
      end
      if (in_valid_i && in_ready_o) ii++;
    end
    check("R4", 128'(ii), 128'(total));
    @(negedge clk_i);
    in_valid_i = 1'b0; out_ready_i = 1'b1;
    rows_i = CFG_W'(rows); bpr_i = CFG_W'(bpr);
    repeat (3) @(negedge clk_i);
    check("R4", {127'b0, out_valid_o}, 128'd0);   // no extra output
    check("R5", {127'b0, in_ready_o}, 128'd1);    // ready for next image
  endtask

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk_i);
    check("R8", {127'b0, out_valid_o}, 128'd0);
    check("R7", {127'b0, in_ready_o}, 128'd0);
    rst_ni = 1'b1;
    // R7 intake gated by start_i
    rows_i = 16'd1; bpr_i = 16'd1; in_valid_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R7", {127'b0, in_ready_o}, 128'd0);
    check("R7", {127'b0, out_valid_o}, 128'd0);
    in_valid_i = 1'b0;
    // table walk
    for (int t = 0; t < NCASE; t++)
      run_image(CASES[t][0], CASES[t][1], CASES[t][2], CASES[t][3], CASES[t][4]);
    // directed: flush step meets a stalled result (R5 R6)
    start_i = 1'b1; rows_i = 16'd1; bpr_i = 16'd2; out_ready_i = 1'b0;
    for (int k = 0; k < 2 * LANES; k++) img[k] = 8'(k * 13 + 1);
    for (int b = 0; b < 2; b++) begin
      for (int l = 0; l < LANES; l++) in_data_i[8*l +: 8] = img[b * LANES + l];
      in_valid_i = 1'b1;
      #1;
      while (!in_ready_o) begin @(negedge clk_i); #1; end
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    #1;
    check("R5", {127'b0, in_ready_o}, 128'd0);
    check("R6", out_data_o, ref_blk(0, 2));
    repeat (2) @(negedge clk_i);
    check("R6", out_data_o, ref_blk(0, 2));
    out_ready_i = 1'b1;
    @(negedge clk_i);
    check("R5", {127'b0, out_valid_o}, 128'd1);
    check("R3", out_data_o, ref_blk(1, 2));
    @(negedge clk_i);
    check("R4", {127'b0, out_valid_o}, 128'd0);
    report();
  end
endmodule